// File: doc/BRIEF.md
# Function-Code-Tagged Direct-Mapped Data Cache

This block sits between a processor's load/store port and a 32-bit external bus. It is a direct-mapped data cache of 16 lines, and each line holds four long words. The key stored with a line is made of the upper address bits together with the full 3-bit function code (address space) of the access. Every long word in a line has its own valid bit, so a line can be partly filled. Read misses fetch from the bus. If the line holds a different key, or holds nothing, the whole line is refilled by a four-beat wrapping burst. If the key already matches and only the wanted long word is missing, a single non-burst long-word read refills that word alone.

Some accesses are never kept: those in the CPU address space (function code 7), and those flagged by the requester as table-walk reads or cross-address-space moves. A read operand that crosses a long-word boundary is split into two lookups, handled in order. One half may hit while the other misses, and each half gives its own response. Writes go through to the bus every time. A write that hits updates the cached long word, and a write that misses leaves the cache as it was. A one-cycle invalidate input clears every valid bit.

Top module: `fcdc_cache`

## Requirements
- R1: After reset every valid bit is clear, the request port is ready, no response is pending and no bus cycle is requested.
- R2: A read hits only when address bits 31..8 and all three function code bits equal the key stored for the line; a mismatch in any of them is a miss.
- R3: Address bits 7..4 select the line and bits 3..2 select the long word and its valid bit; once a line is filled, reads of its other long words hit with no bus cycle.
- R4: A cacheable read miss on a line whose key differs, or which has no valid bit set, issues a four-beat burst (bus_burst high) whose long-word addresses run in wrap order starting at the missed word. It installs the new key and clears the line's other valid bits, and each beat sets its own valid bit.
- R5: A cacheable read miss whose key matches but whose long word is invalid issues exactly one non-burst long-word read and validates only that word.
- R6: Accesses with function code 7 are never stored: a read miss there is one non-burst read, and repeating it misses again.
- R7: Accesses with req_nostore high are never stored: a read miss is one non-burst read, and repeating it misses again.
- R8: A read whose byte offset plus size (byte 1, word 2, long 4, encoded in req_size as 0, 1, 2) exceeds 4 is looked up as two long-word entries, lower address first, each answered by its own response with its own hit flag.
- R9: Every write issues one non-burst bus write of req_wdata. A cacheable write hit updates the cached long word and responds with rsp_hit high. A write miss responds with rsp_hit low and allocates nothing, so a later read of that address misses.
- R10: inv_all clears every valid bit at the next edge. A fill beat that lands in the same cycle is not recorded as valid, while later beats of the same burst still are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| inv_all | input | 1 | Clear all valid bits this cycle |
| req_valid | input | 1 | Access request |
| req_ready | output | 1 | Block idle, request accepted on this edge |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 32 | Byte address |
| req_fc | input | 3 | Function code (address space) |
| req_size | input | 2 | 0 byte, 1 word, 2 or 3 long word |
| req_nostore | input | 1 | Access must not be stored (table walk or cross-space move) |
| req_wdata | input | 32 | Write long word |
| rsp_valid | output | 1 | One-cycle response per looked-up entry |
| rsp_hit | output | 1 | Entry was found in the cache |
| rsp_data | output | 32 | Long word of the entry (write data for writes) |
| bus_req | output | 1 | Bus cycle requested, held until acknowledged |
| bus_we | output | 1 | Bus cycle is a write |
| bus_burst | output | 1 | Bus cycle is part of a four-beat line burst |
| bus_addr | output | 32 | Long-word-aligned bus address of the current beat |
| bus_fc | output | 3 | Function code of the bus cycle |
| bus_wdata | output | 32 | Bus write data |
| bus_ack | input | 1 | Current beat completes on this edge |
| bus_rdata | input | 32 | Read data of the current beat |

## Verification
Invalidate-all and the valid-bit update of a burst fill beat can land on the same edge. The bench raises inv_all together with the acknowledge of the third beat of a burst to a fresh line. It then judges the result through ordinary reads. The last beat's word must hit. The third beat's word, and an earlier beat's word that the invalidate wiped, must each come back through a single non-burst read. A line filled earlier must miss with a full burst.

// File: rtl/fcdc_pkg.sv
// Shared types and constants for the function-code-tagged data cache.
package fcdc_pkg;
    // Controller states.
    typedef enum logic [1:0] {
        ST_IDLE,
        ST_LOOK,
        ST_FILL,
        ST_WBUS
    } cstate_t;

    // Function code of the CPU address space, which is never stored.
    localparam logic [2:0] FC_CPU = 3'd7;
endpackage

// File: rtl/fcdc_tag_store.sv
// Key and per-long-word valid storage for a direct-mapped cache.
// Assumes: one line is written per cycle (the current lookup line); the
// invalidate-all input takes priority over every valid-bit update.
module fcdc_tag_store #(
    parameter int LINES = 16,
    parameter int WORDS = 4,
    parameter int KEY_W = 27,
    localparam int IDX_W = $clog2(LINES),
    localparam int OFF_W = $clog2(WORDS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inv_all,
    input  logic [IDX_W-1:0] idx,
    output logic [KEY_W-1:0] rd_key,
    output logic [WORDS-1:0] rd_vld,
    input  logic             new_en,
    input  logic [KEY_W-1:0] new_key,
    input  logic             set_en,
    input  logic [OFF_W-1:0] set_word
);
    logic [KEY_W-1:0] key_q [LINES];
    logic [WORDS-1:0] vld_q [LINES];
    logic             any_vld;

    // Key write when a new line is allocated.
    always_ff @(posedge clk) begin
        if (new_en) key_q[idx] <= new_key;
    end

    // Valid bits: cleared on reset or invalidate, otherwise allocate/set.
    always_ff @(posedge clk) begin
        if (!rst_n || inv_all) begin
            for (int i = 0; i < LINES; i++) vld_q[i] <= '0;
        end else begin
            if (new_en) vld_q[idx] <= '0;
            if (set_en) vld_q[idx][set_word] <= 1'b1;
        end
    end

    // Lookup read port.
    assign rd_key = key_q[idx];
    assign rd_vld = vld_q[idx];

    // Reduction of all valid bits, used by the checks below.
    always_comb begin
        any_vld = 1'b0;
        for (int i = 0; i < LINES; i++) any_vld = any_vld | (|vld_q[i]);
    end

    // R1
    reset_clear_chk: assert property (@(posedge clk)
        !rst_n |=> !any_vld);

    // R10
    inv_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        inv_all |=> !any_vld);
endmodule

// File: rtl/fcdc_data_store.sv
// Long-word data array of the cache, one read and one write port.
// Assumes: LINES and WORDS are powers of two, so {line, word} is the index.
module fcdc_data_store #(
    parameter int LINES  = 16,
    parameter int WORDS  = 4,
    parameter int DATA_W = 32,
    localparam int IDX_W   = $clog2(LINES),
    localparam int OFF_W   = $clog2(WORDS),
    localparam int ENTRIES = LINES * WORDS
) (
    input  logic              clk,
    input  logic [IDX_W-1:0]  rd_idx,
    input  logic [OFF_W-1:0]  rd_word,
    output logic [DATA_W-1:0] rd_data,
    input  logic              we,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [OFF_W-1:0]  wr_word,
    input  logic [DATA_W-1:0] wr_data
);
    logic [DATA_W-1:0] mem_q [ENTRIES];

    // Write port.
    always_ff @(posedge clk) begin
        if (we) mem_q[{wr_idx, wr_word}] <= wr_data;
    end

    // Asynchronous read of the looked-up long word.
    assign rd_data = mem_q[{rd_idx, rd_word}];
endmodule

// File: rtl/fcdc_ctrl.sv
// Access controller: accepts a request, splits straddling reads into two
// entry lookups, decides hit / single fill / burst fill / write-through and
// runs the bus. Assumes the bus holds no beat without bus_req and answers
// one beat per acknowledge.
module fcdc_ctrl
    import fcdc_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    parameter int LINES  = 16,
    parameter int WORDS  = 4,
    localparam int IDX_W = $clog2(LINES),
    localparam int OFF_W = $clog2(WORDS),
    localparam int WA_W  = ADDR_W - 2,
    localparam int TAG_W = WA_W - OFF_W - IDX_W,
    localparam int KEY_W = TAG_W + 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [2:0]        req_fc,
    input  logic [1:0]        req_size,
    input  logic              req_nostore,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              rsp_valid,
    output logic              rsp_hit,
    output logic [DATA_W-1:0] rsp_data,
    output logic              bus_req,
    output logic              bus_we,
    output logic              bus_burst,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [2:0]        bus_fc,
    output logic [DATA_W-1:0] bus_wdata,
    input  logic              bus_ack,
    input  logic [DATA_W-1:0] bus_rdata,
    output logic [IDX_W-1:0]  lk_idx,
    output logic [OFF_W-1:0]  lk_word,
    input  logic [KEY_W-1:0]  lk_key,
    input  logic [WORDS-1:0]  lk_vld,
    input  logic [DATA_W-1:0] lk_data,
    output logic              tag_new_en,
    output logic [KEY_W-1:0]  tag_new_key,
    output logic              vld_set_en,
    output logic [OFF_W-1:0]  vld_set_word,
    output logic              dat_we,
    output logic [OFF_W-1:0]  dat_word,
    output logic [DATA_W-1:0] dat_wdata
);
    cstate_t           st_q;
    logic [WA_W-1:0]   ent_q;
    logic [2:0]        fc_q;
    logic              wr_q, nost_q, second_q, burst_q, store_q, hit_q;
    logic [DATA_W-1:0] wdata_q, cap_q;
    logic [OFF_W-1:0]  beat_q, cnt_q;
    logic              rsp_valid_q, rsp_hit_q;
    logic [DATA_W-1:0] rsp_data_q;
    logic [2:0]        nbytes;
    logic [3:0]        end_pos;
    logic              straddle, tag_match, hit, cachable, last_beat;

    // Straddle detection from byte offset and operand size.
    always_comb begin
        case (req_size)
            2'd0:    nbytes = 3'd1;
            2'd1:    nbytes = 3'd2;
            default: nbytes = 3'd4;
        endcase
        end_pos  = {2'b00, req_addr[1:0]} + {1'b0, nbytes};
        straddle = end_pos > 4'd4;
    end

    // Lookup decode for the current entry.
    assign lk_idx      = ent_q[OFF_W+IDX_W-1:OFF_W];
    assign lk_word     = ent_q[OFF_W-1:0];
    assign tag_new_key = {ent_q[WA_W-1:OFF_W+IDX_W], fc_q};
    assign tag_match   = (|lk_vld) && (lk_key == tag_new_key);
    assign hit         = tag_match && lk_vld[lk_word];
    assign cachable    = (fc_q != FC_CPU) && !nost_q;
    assign last_beat   = !burst_q || (cnt_q == OFF_W'(WORDS - 1));

    // Storage strobes for allocation, write hits and fill beats.
    always_comb begin
        tag_new_en = (st_q == ST_LOOK) && !wr_q && !hit && cachable && !tag_match;
        dat_we     = (st_q == ST_LOOK) && wr_q && hit && cachable;
        dat_word   = lk_word;
        dat_wdata  = wdata_q;
        vld_set_en = 1'b0;
        if ((st_q == ST_FILL) && bus_ack && store_q) begin
            dat_we     = 1'b1;
            dat_word   = beat_q;
            dat_wdata  = bus_rdata;
            vld_set_en = 1'b1;
        end
    end
    assign vld_set_word = beat_q;

    // Bus and port outputs.
    assign req_ready = (st_q == ST_IDLE);
    assign bus_req   = (st_q == ST_FILL) || (st_q == ST_WBUS);
    assign bus_we    = (st_q == ST_WBUS);
    assign bus_burst = (st_q == ST_FILL) && burst_q;
    assign bus_addr  = {ent_q[WA_W-1:OFF_W], beat_q, 2'b00};
    assign bus_fc    = fc_q;
    assign bus_wdata = wdata_q;
    assign rsp_valid = rsp_valid_q;
    assign rsp_hit   = rsp_hit_q;
    assign rsp_data  = rsp_data_q;

    // Sequencer: request capture, lookup, fill beats and write-through.
    always_ff @(posedge clk) begin
        rsp_valid_q <= 1'b0;
        if (!rst_n) begin
            st_q     <= ST_IDLE;
            second_q <= 1'b0;
        end else begin
            case (st_q)
                ST_IDLE: if (req_valid) begin
                    ent_q    <= req_addr[ADDR_W-1:2];
                    fc_q     <= req_fc;
                    wr_q     <= req_write;
                    nost_q   <= req_nostore;
                    wdata_q  <= req_wdata;
                    second_q <= !req_write && straddle;
                    st_q     <= ST_LOOK;
                end
                ST_LOOK: begin
                    beat_q <= lk_word;
                    cnt_q  <= '0;
                    hit_q  <= hit;
                    if (wr_q) begin
                        st_q <= ST_WBUS;
                    end else if (hit) begin
                        rsp_valid_q <= 1'b1;
                        rsp_hit_q   <= 1'b1;
                        rsp_data_q  <= lk_data;
                        if (second_q) begin
                            second_q <= 1'b0;
                            ent_q    <= ent_q + 1'b1;
                            st_q     <= ST_LOOK;
                        end else begin
                            st_q <= ST_IDLE;
                        end
                    end else begin
                        burst_q <= cachable && !tag_match;
                        store_q <= cachable;
                        st_q    <= ST_FILL;
                    end
                end
                ST_FILL: if (bus_ack) begin
                    if (cnt_q == '0) cap_q <= bus_rdata;
                    if (last_beat) begin
                        rsp_valid_q <= 1'b1;
                        rsp_hit_q   <= 1'b0;
                        rsp_data_q  <= (cnt_q == '0) ? bus_rdata : cap_q;
                        if (second_q) begin
                            second_q <= 1'b0;
                            ent_q    <= ent_q + 1'b1;
                            st_q     <= ST_LOOK;
                        end else begin
                            st_q <= ST_IDLE;
                        end
                    end else begin
                        beat_q <= beat_q + 1'b1;
                        cnt_q  <= cnt_q + 1'b1;
                    end
                end
                ST_WBUS: if (bus_ack) begin
                    rsp_valid_q <= 1'b1;
                    rsp_hit_q   <= hit_q;
                    rsp_data_q  <= wdata_q;
                    st_q        <= ST_IDLE;
                end
                default: st_q <= ST_IDLE;
            endcase
        end
    end

    logic [OFF_W-1:0] bus_word;
    assign bus_word = bus_addr[OFF_W+1:2];

    // R4
    burst_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && bus_burst && bus_ack && !last_beat)
        |=> (bus_burst && (bus_word == $past(bus_word) + 1'b1)));

    // R4
    bus_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && !bus_ack) |=> (bus_req && $stable(bus_addr)));

    // R5
    single_beat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && !bus_burst && !bus_we && bus_ack) |=> !bus_req);

    // R6
    cpu_space_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
        vld_set_en |-> (bus_fc != FC_CPU));

    // R7
    nostore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (vld_set_en || tag_new_en) |-> !nost_q);

    // R9
    write_noalloc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_we |-> (!tag_new_en && !vld_set_en));
endmodule

// File: rtl/fcdc_cache.sv
// Top of the function-code-tagged direct-mapped data cache: controller,
// key/valid store and data array. Assumes long-word-aligned bus beats.
module fcdc_cache #(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    parameter int LINES  = 16,
    parameter int WORDS  = 4,
    localparam int IDX_W = $clog2(LINES),
    localparam int OFF_W = $clog2(WORDS),
    localparam int KEY_W = ADDR_W - 2 - OFF_W - IDX_W + 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              inv_all,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [2:0]        req_fc,
    input  logic [1:0]        req_size,
    input  logic              req_nostore,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              rsp_valid,
    output logic              rsp_hit,
    output logic [DATA_W-1:0] rsp_data,
    output logic              bus_req,
    output logic              bus_we,
    output logic              bus_burst,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [2:0]        bus_fc,
    output logic [DATA_W-1:0] bus_wdata,
    input  logic              bus_ack,
    input  logic [DATA_W-1:0] bus_rdata
);
    logic [IDX_W-1:0]  lk_idx;
    logic [OFF_W-1:0]  lk_word, vld_set_word, dat_word;
    logic [KEY_W-1:0]  lk_key, tag_new_key;
    logic [WORDS-1:0]  lk_vld;
    logic [DATA_W-1:0] lk_data, dat_wdata;
    logic              tag_new_en, vld_set_en, dat_we;

    fcdc_ctrl #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .LINES(LINES), .WORDS(WORDS)
    ) ctrl_i (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_addr(req_addr), .req_fc(req_fc), .req_size(req_size),
        .req_nostore(req_nostore), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_data(rsp_data),
        .bus_req(bus_req), .bus_we(bus_we), .bus_burst(bus_burst),
        .bus_addr(bus_addr), .bus_fc(bus_fc), .bus_wdata(bus_wdata),
        .bus_ack(bus_ack), .bus_rdata(bus_rdata),
        .lk_idx(lk_idx), .lk_word(lk_word), .lk_key(lk_key), .lk_vld(lk_vld),
        .lk_data(lk_data), .tag_new_en(tag_new_en), .tag_new_key(tag_new_key),
        .vld_set_en(vld_set_en), .vld_set_word(vld_set_word),
        .dat_we(dat_we), .dat_word(dat_word), .dat_wdata(dat_wdata)
    );

    fcdc_tag_store #(
        .LINES(LINES), .WORDS(WORDS), .KEY_W(KEY_W)
    ) tags_i (
        .clk(clk), .rst_n(rst_n), .inv_all(inv_all), .idx(lk_idx),
        .rd_key(lk_key), .rd_vld(lk_vld),
        .new_en(tag_new_en), .new_key(tag_new_key),
        .set_en(vld_set_en), .set_word(vld_set_word)
    );

    fcdc_data_store #(
        .LINES(LINES), .WORDS(WORDS), .DATA_W(DATA_W)
    ) data_i (
        .clk(clk), .rd_idx(lk_idx), .rd_word(lk_word), .rd_data(lk_data),
        .we(dat_we), .wr_idx(lk_idx), .wr_word(dat_word), .wr_data(dat_wdata)
    );
endmodule

// File: tb/fcdc_cache_tb.sv
// Scoreboard bench: the driver task queues expected responses, a monitor
// pops them as responses appear, and a bus model answers one beat per cycle.
module fcdc_cache_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        inv_drv = 1'b0, inv_bus = 1'b0, inv_all;
    logic        req_valid = 1'b0, req_write = 1'b0, req_nostore = 1'b0;
    logic [31:0] req_addr = '0, req_wdata = '0;
    logic [2:0]  req_fc = '0;
    logic [1:0]  req_size = '0;
    logic        req_ready, rsp_valid, rsp_hit;
    logic [31:0] rsp_data;
    logic        bus_req, bus_we, bus_burst;
    logic [31:0] bus_addr, bus_wdata;
    logic [2:0]  bus_fc;
    logic        bus_ack = 1'b0;
    logic [31:0] bus_rdata = '0;

    always #10 clk = ~clk;   // 50 MHz
    assign inv_all = inv_drv | inv_bus;

    fcdc_cache dut_i (
        .clk(clk), .rst_n(rst_n), .inv_all(inv_all),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_addr(req_addr), .req_fc(req_fc), .req_size(req_size),
        .req_nostore(req_nostore), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_data(rsp_data),
        .bus_req(bus_req), .bus_we(bus_we), .bus_burst(bus_burst),
        .bus_addr(bus_addr), .bus_fc(bus_fc), .bus_wdata(bus_wdata),
        .bus_ack(bus_ack), .bus_rdata(bus_rdata)
    );

    int          n_chk = 0, n_fail = 0, inv_beat = -1;
    bit          finished = 0;
    logic [31:0] wmem [logic [31:0]];
    logic [31:0] q_data [$];
    logic        q_hit [$];
    string       q_tag [$];
    logic [31:0] blog [$];
    logic        b_burst = 1'b0, b_we = 1'b0;
    logic [31:0] m_d;
    logic        m_h;
    string       m_t;

    function automatic logic [31:0] mval(input logic [31:0] a);
        logic [31:0] al;
        al = {a[31:2], 2'b00};
        if (wmem.exists(al)) return wmem[al];
        return al ^ 32'h5A3C_00C3;
    endfunction

    task automatic chk(input bit ok, input string rq, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", rq, what, act, exp);
        end
    endtask

    // Monitor: compare each response with the head of the scoreboard.
    always @(negedge clk) begin
        if (rst_n && rsp_valid) begin
            if (q_data.size() == 0) begin
                chk(1'b0, "R8", "unexpected response", rsp_data, 32'h0);
            end else begin
                m_d = q_data.pop_front();
                m_h = q_hit.pop_front();
                m_t = q_tag.pop_front();
                chk(rsp_data == m_d, m_t, "response data", rsp_data, m_d);
                chk(rsp_hit == m_h, m_t, "response hit", {31'b0, rsp_hit}, {31'b0, m_h});
            end
        end
    end

    // Bus model: acknowledge every requested beat one cycle later, log it.
    initial begin
        forever begin
            @(negedge clk);
            if (bus_req) begin
                blog.push_back(bus_addr);
                b_burst   = bus_burst;
                b_we      = bus_we;
                bus_rdata = bus_we ? 32'h0 : mval(bus_addr);
                bus_ack   = 1'b1;
                inv_bus   = (inv_beat == blog.size() - 1);
            end else begin
                bus_ack = 1'b0;
                inv_bus = 1'b0;
            end
        end
    end

    // Driver: queue expectations, issue one access, then check bus traffic.
    task automatic op(input logic wr, input logic [31:0] a, input logic [2:0] fc,
                      input logic [1:0] sz, input logic ns, input logic [31:0] wd,
                      input logic h0, input logic h1, input int nb, input logic bst,
                      input logic [31:0] first, input string tag);
        logic [31:0] e0;
        int nby;
        bit strad;
        e0    = {a[31:2], 2'b00};
        nby   = (sz == 2'd0) ? 1 : (sz == 2'd1) ? 2 : 4;
        strad = !wr && ((int'(a[1:0]) + nby) > 4);
        if (wr) begin
            q_data.push_back(wd); q_hit.push_back(h0); q_tag.push_back(tag);
            wmem[e0] = wd;
        end else begin
            q_data.push_back(mval(e0)); q_hit.push_back(h0); q_tag.push_back(tag);
            if (strad) begin
                q_data.push_back(mval(e0 + 32'd4)); q_hit.push_back(h1); q_tag.push_back(tag);
            end
        end
        blog.delete();
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_addr = a; req_fc = fc;
        req_size = sz; req_nostore = ns; req_wdata = wd;
        while (!req_ready) @(negedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        while (q_data.size() != 0) @(negedge clk);
        repeat (2) @(negedge clk);
        chk(blog.size() == nb, tag, "bus beat count", blog.size(), nb);
        if (nb > 0 && blog.size() > 0) begin
            chk(b_we == wr, tag, "bus direction", {31'b0, b_we}, {31'b0, wr});
            chk(b_burst == bst, tag, "burst flag", {31'b0, b_burst}, {31'b0, bst});
            chk(blog[0] == first, tag, "first beat address", blog[0], first);
            if (bst && blog.size() == 4) begin
                for (int k = 1; k < 4; k++) begin
                    logic [31:0] ea;
                    ea = {first[31:4], 2'(first[3:2] + k), 2'b00};
                    chk(blog[k] == ea, tag, "wrap order", blog[k], ea);
                end
            end
        end
    endtask

    // Watchdog: a hung run is a failed check and still prints the summary.
    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(req_ready == 1'b1, "R1", "req_ready after reset", {31'b0, req_ready}, 32'd1);
        chk(rsp_valid == 1'b0, "R1", "rsp_valid after reset", {31'b0, rsp_valid}, 32'd0);
        chk(bus_req == 1'b0, "R1", "bus_req after reset", {31'b0, bus_req}, 32'd0);
        // R1/R4: empty cache misses with a wrapping burst from word 1
        op(0, 32'h1014, 3'd5, 2'd2, 0, 0, 0, 0, 4, 1, 32'h1014, "R1");
        // R3: other words of the line hit without bus cycles
        op(0, 32'h101C, 3'd5, 2'd2, 0, 0, 1, 0, 0, 0, 32'h0, "R3");
        op(0, 32'h1010, 3'd5, 2'd2, 0, 0, 1, 0, 0, 0, 32'h0, "R3");
        // R2: function code mismatch misses and refills by burst
        op(0, 32'h1014, 3'd1, 2'd2, 0, 0, 0, 0, 4, 1, 32'h1014, "R2");
        // R4: key change back, burst wraps from word 2
        op(0, 32'h1018, 3'd5, 2'd2, 0, 0, 0, 0, 4, 1, 32'h1018, "R4");
        // R2: same index, different upper address
        op(0, 32'h2014, 3'd5, 2'd2, 0, 0, 0, 0, 4, 1, 32'h2014, "R2");
        op(0, 32'h101C, 3'd5, 2'd2, 0, 0, 0, 0, 4, 1, 32'h101C, "R4");
        // R6: CPU space is never stored
        op(0, 32'h3008, 3'd7, 2'd2, 0, 0, 0, 0, 1, 0, 32'h3008, "R6");
        op(0, 32'h3008, 3'd7, 2'd2, 0, 0, 0, 0, 1, 0, 32'h3008, "R6");
        // R7: no-store flag
        op(0, 32'h4004, 3'd5, 2'd2, 1, 0, 0, 0, 1, 0, 32'h4004, "R7");
        op(0, 32'h4004, 3'd5, 2'd2, 1, 0, 0, 0, 1, 0, 32'h4004, "R7");
        // R9: write hit updates and writes through
        op(1, 32'h1018, 3'd5, 2'd2, 0, 32'hDEAD_BEEF, 1, 0, 1, 0, 32'h1018, "R9");
        op(0, 32'h1018, 3'd5, 2'd2, 0, 0, 1, 0, 0, 0, 32'h0, "R9");
        // R9: write miss does not allocate
        op(1, 32'h5008, 3'd5, 2'd2, 0, 32'h0BAD_F00D, 0, 0, 1, 0, 32'h5008, "R9");
        op(0, 32'h5008, 3'd5, 2'd2, 0, 0, 0, 0, 4, 1, 32'h5008, "R9");
        // R8: straddling reads, hit then miss, and miss then hit
        op(0, 32'h101E, 3'd5, 2'd2, 0, 0, 1, 0, 4, 1, 32'h1020, "R8");
        op(0, 32'h102F, 3'd5, 2'd1, 0, 0, 1, 0, 4, 1, 32'h1030, "R8");
        op(0, 32'h100E, 3'd5, 2'd2, 0, 0, 0, 1, 4, 1, 32'h100C, "R8");
        op(0, 32'h1033, 3'd5, 2'd0, 0, 0, 1, 0, 0, 0, 32'h0, "R8");
        // R10: invalidate lands with the third burst beat (word 3)
        inv_beat = 2;
        op(0, 32'h6044, 3'd5, 2'd2, 0, 0, 0, 0, 4, 1, 32'h6044, "R10");
        inv_beat = -1;
        op(0, 32'h6040, 3'd5, 2'd2, 0, 0, 1, 0, 0, 0, 32'h0, "R10");
        // R5: key matches, word invalid: single long-word refill
        op(0, 32'h604C, 3'd5, 2'd2, 0, 0, 0, 0, 1, 0, 32'h604C, "R5");
        op(0, 32'h604C, 3'd5, 2'd2, 0, 0, 1, 0, 0, 0, 32'h0, "R5");
        op(0, 32'h6048, 3'd5, 2'd2, 0, 0, 0, 0, 1, 0, 32'h6048, "R5");
        // R10: earlier line was wiped by the invalidate
        op(0, 32'h1010, 3'd5, 2'd2, 0, 0, 0, 0, 4, 1, 32'h1010, "R10");
        // R10: invalidate while idle
        @(negedge clk); inv_drv = 1'b1;
        @(negedge clk); inv_drv = 1'b0;
        op(0, 32'h6040, 3'd5, 2'd2, 0, 0, 0, 0, 4, 1, 32'h6040, "R10");
        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule